// File: doc/BRIEF.md
# Interlocked Parallel Port Handshake Controller

This block runs a fully interlocked, four-phase strobe/acknowledge handshake for one byte-wide parallel port. A mode input turns the port into a sender or a receiver. As a sender, the block takes a byte from a local write strobe and drives it onto the port pads. It then lowers an active-low data-available strobe. It waits for the far end to pull its ready line low, releases the strobe, and waits for ready to come back high before it takes another byte.

As a receiver, the block watches the far end's active-low strobe. On a falling strobe it captures the pad byte into a single-entry buffer, pulls its own ready output low and raises a byte-received flag. Ready goes high again only when two things are true: the strobe has returned high, and local logic has read the byte. A sender that follows the protocol is therefore held off until the buffer is free. Both incoming handshake lines pass through multi-flop synchronisers before any edge or level is acted on.

Top module: `port_hs_ctrl`

## Requirements
- R1: Out of reset, `avail_n_o` and `ready_o` are both 1, `busy` and `rx_full` are 0.
- R2: In send mode (`dir_out`=1), a `wr_valid` pulse while idle puts `wr_data` on `pad_dout` and sets `busy` at the next clock edge. With `SETUP_CYC`=1, `avail_n_o` falls one edge later, provided `ready_i` has been seen high through the synchroniser. The byte on `pad_dout` is stable from at least one clock before that fall.
- R3: While `avail_n_o` is low, `pad_dout` holds its value. `avail_n_o` returns to 1 on the third clock edge after `ready_i` goes low (two synchroniser edges plus one state edge).
- R4: `busy` stays 1 until the synchronised `ready_i` is high again, and clears on the third edge after `ready_i` rises. If `ready_i` is low when a byte is written, `avail_n_o` stays high until the third edge after `ready_i` rises.
- R5: `wr_valid` has no effect while `busy` is 1 or while `dir_out` is 0. `pad_oe` equals `dir_out`.
- R6: In receive mode (`dir_out`=0), `ready_o` goes to 0 and `rx_full` to 1 on the third edge after `avail_n_i` falls. `rd_data` then holds the `pad_din` value present at that edge, and keeps it when `pad_din` later changes.
- R7: If the byte has already been read, `ready_o` returns to 1 on the third edge after `avail_n_i` rises.
- R8: While `rx_full` is 1, `ready_o` stays 0 even with `avail_n_i` high. A `rd_strobe` clears `rx_full` at the next edge, and if the synchronised strobe is high, `ready_o` returns to 1 at that same edge.
- R9: In send mode, activity on `avail_n_i` leaves `ready_o` at 1 and `rx_full` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_out | input | 1 | 1 = send mode, 0 = receive mode |
| wr_valid | input | 1 | Local write strobe for a byte to send |
| wr_data | input | DATA_W | Byte to send |
| busy | output | 1 | Send transfer in progress |
| rd_strobe | input | 1 | Local read of the received byte |
| rd_data | output | DATA_W | Received byte buffer |
| rx_full | output | 1 | Byte received and not yet read |
| pad_din | input | DATA_W | Port pad input data |
| pad_dout | output | DATA_W | Port pad output data |
| pad_oe | output | 1 | Pad output enable |
| avail_n_i | input | 1 | Far-end data-available strobe, active low |
| ready_o | output | 1 | Ready/acknowledge driven to the far end |
| avail_n_o | output | 1 | Data-available strobe driven to the far end, active low |
| ready_i | input | 1 | Ready/acknowledge from the far end |

## Verification
A send state machine stuck in or skipping a phase shows at the pins within one handshake. `avail_n_o` fails to fall two edges after the write, or fails to rise three edges after `ready_i` drops, or `busy` outlives the returning ready. A receive side that loses its buffer state shows as `ready_o` rising before the local read, or as a changed `rd_data` once the pads move after the acknowledge. A wrong synchroniser depth moves every reaction away from the third edge and is caught on the first transfer.

// File: rtl/hs_pkg.sv
package hs_pkg;
    typedef enum logic [1:0] {
        TX_IDLE    = 2'd0,
        TX_SETUP   = 2'd1,
        TX_STROBE  = 2'd2,
        TX_RELEASE = 2'd3
    } tx_state_e;

    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_HELD = 1'b1
    } rx_state_e;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = {sr_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= {STAGES{RST_VAL}};
        else        sr_q <= sr_d;
    end

    assign q = sr_q[STAGES-1];
endmodule

// File: rtl/hs_tx.sv
module hs_tx
    import hs_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int SETUP_CYC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ready_s,
    output logic              busy,
    output logic              avail_n,
    output logic [DATA_W-1:0] dout
);
    localparam int CNT_W = (SETUP_CYC < 2) ? 1 : $clog2(SETUP_CYC);

    typedef struct packed {
        tx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] data;
    } tx_regs_t;

    tx_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            TX_IDLE: begin
                if (enable && wr_valid) begin
                    r_d.st   = TX_SETUP;
                    r_d.data = wr_data;
                    r_d.cnt  = CNT_W'(SETUP_CYC - 1);
                end
            end
            TX_SETUP: begin
                if (r_q.cnt != '0) r_d.cnt = r_q.cnt - 1'b1;
                else if (ready_s)  r_d.st  = TX_STROBE;
            end
            TX_STROBE: begin
                if (!ready_s) r_d.st = TX_RELEASE;
            end
            TX_RELEASE: begin
                if (ready_s) r_d.st = TX_IDLE;
            end
            default: r_d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= TX_IDLE;
            r_q.cnt  <= '0;
            r_q.data <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy    = (r_q.st != TX_IDLE);
    assign avail_n = (r_q.st != TX_STROBE);
    assign dout    = r_q.data;
endmodule

// File: rtl/hs_rx.sv
module hs_rx
    import hs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              avail_s,
    input  logic [DATA_W-1:0] din,
    input  logic              rd_strobe,
    output logic              ready,
    output logic              full,
    output logic [DATA_W-1:0] data
);
    typedef struct packed {
        rx_state_e         st;
        logic              prev;
        logic              full;
        logic [DATA_W-1:0] buffer;
    } rx_regs_t;

    rx_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.prev = avail_s;
        if (rd_strobe) r_d.full = 1'b0;
        case (r_q.st)
            RX_IDLE: begin
                if (enable && r_q.prev && !avail_s) begin
                    r_d.st     = RX_HELD;
                    r_d.full   = 1'b1;
                    r_d.buffer = din;
                end
            end
            RX_HELD: begin
                if (avail_s && !r_d.full) r_d.st = RX_IDLE;
            end
            default: r_d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st     <= RX_IDLE;
            r_q.prev   <= 1'b1;
            r_q.full   <= 1'b0;
            r_q.buffer <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ready = (r_q.st == RX_IDLE);
    assign full  = r_q.full;
    assign data  = r_q.buffer;
endmodule

// File: rtl/port_hs_ctrl.sv
module port_hs_ctrl #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int SETUP_CYC   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dir_out,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              busy,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_full,
    input  logic [DATA_W-1:0] pad_din,
    output logic [DATA_W-1:0] pad_dout,
    output logic              pad_oe,
    input  logic              avail_n_i,
    output logic              ready_o,
    output logic              avail_n_o,
    input  logic              ready_i
);
    logic ready_s;
    logic avail_s;

    hs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ready (
        .clk(clk), .rst_n(rst_n), .d(ready_i), .q(ready_s)
    );

    hs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_avail (
        .clk(clk), .rst_n(rst_n), .d(avail_n_i), .q(avail_s)
    );

    hs_tx #(.DATA_W(DATA_W), .SETUP_CYC(SETUP_CYC)) u_tx (
        .clk(clk), .rst_n(rst_n), .enable(dir_out),
        .wr_valid(wr_valid), .wr_data(wr_data), .ready_s(ready_s),
        .busy(busy), .avail_n(avail_n_o), .dout(pad_dout)
    );

    hs_rx #(.DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .enable(!dir_out),
        .avail_s(avail_s), .din(pad_din), .rd_strobe(rd_strobe),
        .ready(ready_o), .full(rx_full), .data(rd_data)
    );

    assign pad_oe = dir_out;
endmodule

// File: rtl/port_hs_ctrl_chk.sv
module port_hs_ctrl_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              rx_full,
    input logic              ready_o,
    input logic              avail_n_o,
    input logic [DATA_W-1:0] pad_dout,
    input logic              ready_s,
    input logic              avail_s
);
    AST_STROBE_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(avail_n_o) |-> $past(ready_s)); // R2
    AST_DATA_BEFORE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(avail_n_o) |-> $stable(pad_dout)); // R2
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!avail_n_o && $past(!avail_n_o)) |-> $stable(pad_dout)); // R3
    AST_RELEASE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(avail_n_o) |-> !$past(ready_s)); // R3
    AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !avail_n_o |-> busy); // R4
    AST_FULL_SETS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> $fell(ready_o)); // R6
    AST_READY_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(avail_s)); // R7
    AST_FULL_BLOCKS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |-> !ready_o); // R8
endmodule

bind port_hs_ctrl port_hs_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .rx_full(rx_full),
    .ready_o(ready_o), .avail_n_o(avail_n_o), .pad_dout(pad_dout),
    .ready_s(ready_s), .avail_s(avail_s)
);

// File: tb/port_hs_ctrl_test.sv
`timescale 1ns/1ps
module port_hs_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dir_out = 1'b1;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       busy;
    logic       rd_strobe = 1'b0;
    logic [7:0] rd_data;
    logic       rx_full;
    logic [7:0] pad_din = '0;
    logic [7:0] pad_dout;
    logic       pad_oe;
    logic       avail_n_i = 1'b1;
    logic       ready_o;
    logic       avail_n_o;
    logic       ready_i = 1'b1;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    port_hs_ctrl uut (
        .clk(clk), .rst_n(rst_n), .dir_out(dir_out), .wr_valid(wr_valid),
        .wr_data(wr_data), .busy(busy), .rd_strobe(rd_strobe),
        .rd_data(rd_data), .rx_full(rx_full), .pad_din(pad_din),
        .pad_dout(pad_dout), .pad_oe(pad_oe), .avail_n_i(avail_n_i),
        .ready_o(ready_o), .avail_n_o(avail_n_o), .ready_i(ready_i)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tick(3);
        check("R1 avail_n_o", avail_n_o, 1);
        check("R1 ready_o", ready_o, 1);
        check("R1 busy", busy, 0);
        check("R1 rx_full", rx_full, 0);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic t_tx_basic();
        dir_out = 1'b1;
        wr_data = 8'hA5; wr_valid = 1'b1;
        tick(1);
        wr_valid = 1'b0;
        check("R2 busy set", busy, 1);
        check("R2 data on pads", pad_dout, 8'hA5);
        check("R2 strobe not yet", avail_n_o, 1);
        check("R5 pad_oe send", pad_oe, 1);
        tick(1);
        check("R2 strobe low", avail_n_o, 0);
        wr_data = 8'h3C; wr_valid = 1'b1;
        tick(1);
        wr_valid = 1'b0;
        check("R5 write while busy ignored", pad_dout, 8'hA5);
        ready_i = 1'b0;
        tick(2);
        check("R3 strobe held", avail_n_o, 0);
        check("R3 data held", pad_dout, 8'hA5);
        tick(1);
        check("R3 strobe released", avail_n_o, 1);
        check("R4 busy until ready", busy, 1);
        ready_i = 1'b1;
        tick(2);
        check("R4 busy before sync", busy, 1);
        tick(1);
        check("R4 busy cleared", busy, 0);
        check("R5 busy write had no effect", pad_dout, 8'hA5);
    endtask

    task automatic t_tx_wait_ready();
        ready_i = 1'b0;
        tick(4);
        wr_data = 8'h5A; wr_valid = 1'b1;
        tick(1);
        wr_valid = 1'b0;
        tick(3);
        check("R4 no strobe while ready low", avail_n_o, 1);
        ready_i = 1'b1;
        tick(2);
        check("R4 strobe waits for sync", avail_n_o, 1);
        tick(1);
        check("R4 strobe after ready", avail_n_o, 0);
        ready_i = 1'b0;
        tick(3);
        ready_i = 1'b1;
        tick(3);
        check("R4 idle again", busy, 0);
    endtask

    task automatic t_tx_ignored_rx_mode();
        dir_out = 1'b0;
        tick(1);
        wr_data = 8'hFF; wr_valid = 1'b1;
        tick(1);
        wr_valid = 1'b0;
        tick(1);
        check("R5 write ignored busy", busy, 0);
        check("R5 write ignored strobe", avail_n_o, 1);
        check("R5 pad_oe receive", pad_oe, 0);
        check("R5 pads unchanged", pad_dout, 8'h5A);
    endtask

    task automatic t_rx_hold_until_read();
        dir_out = 1'b0;
        pad_din = 8'hC3; avail_n_i = 1'b0;
        tick(2);
        check("R6 ready before sync", ready_o, 1);
        tick(1);
        check("R6 ready low", ready_o, 0);
        check("R6 full set", rx_full, 1);
        check("R6 byte captured", rd_data, 8'hC3);
        pad_din = 8'h11;
        tick(1);
        check("R6 byte kept", rd_data, 8'hC3);
        avail_n_i = 1'b1;
        tick(5);
        check("R8 ready held while full", ready_o, 0);
        rd_strobe = 1'b1;
        tick(1);
        rd_strobe = 1'b0;
        check("R8 full cleared", rx_full, 0);
        check("R8 ready after read", ready_o, 1);
    endtask

    task automatic t_rx_read_early();
        pad_din = 8'h96; avail_n_i = 1'b0;
        tick(3);
        check("R6 second byte", rd_data, 8'h96);
        rd_strobe = 1'b1;
        tick(1);
        rd_strobe = 1'b0;
        check("R7 full cleared early", rx_full, 0);
        check("R7 ready low while strobe low", ready_o, 0);
        avail_n_i = 1'b1;
        tick(2);
        check("R7 ready before sync", ready_o, 0);
        tick(1);
        check("R7 ready high", ready_o, 1);
    endtask

    task automatic t_rx_ignored_tx_mode();
        dir_out = 1'b1;
        tick(1);
        pad_din = 8'h77; avail_n_i = 1'b0;
        tick(5);
        check("R9 ready stays high", ready_o, 1);
        check("R9 no byte flagged", rx_full, 0);
        avail_n_i = 1'b1;
        tick(4);
        check("R9 still idle", ready_o, 1);
    endtask

    initial begin
        tick(1);
        t_reset();
        t_tx_basic();
        t_tx_wait_ready();
        t_tx_ignored_rx_mode();
        t_rx_hold_until_read();
        t_rx_read_early();
        t_rx_ignored_tx_mode();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule